// File: doc/BRIEF.md
# Hot-Plug Slot Power Sequencer

This block controls one pluggable mezzanine module slot. It sequences the slot's two power tiers and the hot-plug signals to a downstream hot-plug controller. Once the module is seen as present, only the management rail comes up. The payload rail waits until the shelf manager approves the module. With both rails up, the block drives the hot-plug presence and attention-button lines of the downstream controller so that controller raises a presence-change interrupt. The host turns on its power indicator when configuration is complete, and the block takes that as confirmation that the insertion is done.

Removal begins when the module handle is opened. It goes ahead only if the shelf manager permits it. The block presses the attention button and waits for the host to turn its power indicator off. It then requests the blue service LED, drops the payload rail, and drops the management rail last. Each wait for a handshake is bounded by a timeout. When a timeout expires, the block flags an error and holds every rail off. Losing presence in any state removes all power at once.

All inputs are asynchronous. Each one passes through a two-flop synchroniser. The presence and handle inputs are also debounced. Separately from the sequencer, the block registers the module enable as the AND of the management controller's active-low reset line and the active-low presence input.

Top module: `hps_slot_sequencer`

## Requirements
- R1: While reset is held, both rail enables, the LED request and the error flag are 0, hpPrsntN and hpAttnN are 1, and modEnableN is 0.
- R2: presentN (0 = present) passes two synchroniser flops and must then hold steady for DEB_CYCLES cycles. The management rail turns on at the clock edge 3 + DEB_CYCLES after the input changes, and the payload rail stays off. A pulse shorter than DEB_CYCLES cycles has no effect.
- R3: The payload rail turns on only after approveIn is 1. This happens three clock edges after approveIn rises. The management rail is already on in the cycle before.
- R4: While the payload rail is on and the host power indicator (pwrInd, 1 = on) has not yet been seen, hpPrsntN and hpAttnN are both 0. Three edges after pwrInd rises, hpAttnN returns to 1, and hpPrsntN stays at 0.
- R5: Opening the handle (handleOpen = 1) while removeOk is 0 leaves hpAttnN at 1 and both rails on.
- R6: When the debounced handle is open and removeOk is 1, hpAttnN goes to 0. Both rails stay on until pwrInd falls.
- R7: Three edges after pwrInd falls during a removal, the LED request turns on with both rails still on. STEP_CYCLES edges later the payload rail turns off. After another STEP_CYCLES edges the management rail turns off. The LED stays on.
- R8: The payload rail is never on while the management rail is off.
- R9: If approval, confirmation or host release is missing for TIMEOUT_CYCLES cycles in its wait state, errFlag goes to 1 and both rails turn off. This holds until presence is lost.
- R10: When debounced presence is lost in any state, the block returns to idle. Both rails, the LED request and errFlag turn off, and hpPrsntN and hpAttnN go to 1.
- R11: modEnableN is the AND of mmcResetN and presentN. It changes at the third clock edge after either input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| presentN | input | 1 | Module presence, active low, asynchronous |
| mmcResetN | input | 1 | Management controller reset line, active low |
| approveIn | input | 1 | Shelf manager approval for payload power |
| handleOpen | input | 1 | Module handle open, asynchronous |
| removeOk | input | 1 | Shelf manager permits removal |
| pwrInd | input | 1 | Power indicator from the downstream hot-plug controller |
| mgmtPwrEn | output | 1 | Management rail enable |
| payloadPwrEn | output | 1 | Payload rail enable |
| hpPrsntN | output | 1 | Hot-plug presence to the downstream controller, active low |
| hpAttnN | output | 1 | Hot-plug attention button, active low |
| blueLedReq | output | 1 | Blue service LED request |
| errFlag | output | 1 | Handshake timeout error |
| modEnableN | output | 1 | Module enable, active low |

## Verification
The bench targets the exact edge at which each tier changes:
- A debouncer that is off by one, or a missing synchroniser stage, would move the management rail or the removal steps by a cycle.
- A presence glitch shorter than the debounce window probes premature power-up.
- A handle that opens without permission catches an attention press sent without approval.
- A host that never releases its indicator shows whether a design drops the rails early or hangs instead of faulting.
- Presence pulled mid-sequence and timeouts in each wait state check that every path returns all rails to off.

// File: rtl/hps_pkg.sv
package hps_pkg;

  localparam int NUM_IN     = 6;
  localparam int IDX_PRES   = 0;
  localparam int IDX_HANDLE = 1;
  localparam int IDX_APPR   = 2;
  localparam int IDX_RMOK   = 3;
  localparam int IDX_PIND   = 4;
  localparam int IDX_MMC    = 5;

  // Safe idle values: absent module, management reset held.
  localparam logic [NUM_IN-1:0] SYNC_RST = 6'b000001;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MGMT_WAIT,
    ST_ANNOUNCE,
    ST_ACTIVE,
    ST_RELEASE,
    ST_LED,
    ST_DROP_PAYLOAD,
    ST_PARKED,
    ST_FAULT
  } hps_state_e;

  // control -> datapath
  typedef struct packed {
    logic mgmtOn;
    logic payloadOn;
    logic announce;
    logic attention;
    logic ledOn;
    logic fault;
    logic clrTimer;
  } hps_drive_t;

  // datapath -> control
  typedef struct packed {
    logic present;
    logic handle;
    logic approved;
    logic removeOk;
    logic pwrInd;
    logic timeoutHit;
    logic stepDone;
  } hps_status_t;

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/hps_debounce.sv
module hps_debounce #(
  parameter int   CYCLES  = 16,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic stable
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stable <= RST_VAL;
      cnt    <= '0;
    end else if (din != stable) begin
      if (cnt == CW'(CYCLES - 1)) begin
        stable <= din;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else begin
      cnt <= '0;
    end
  end
endmodule

// File: rtl/hps_datapath.sv
module hps_datapath
  import hps_pkg::*;
#(
  parameter int DEB_CYCLES     = 16,
  parameter int TIMEOUT_CYCLES = 100000,
  parameter int STEP_CYCLES    = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        presentN,
  input  logic        mmcResetN,
  input  logic        approveIn,
  input  logic        handleOpen,
  input  logic        removeOk,
  input  logic        pwrInd,
  input  hps_drive_t  drv,
  output hps_status_t stat,
  output logic        mgmtPwrEn,
  output logic        payloadPwrEn,
  output logic        hpPrsntN,
  output logic        hpAttnN,
  output logic        blueLedReq,
  output logic        errFlag,
  output logic        modEnableN
);
  localparam int TMAX = (TIMEOUT_CYCLES > STEP_CYCLES) ? TIMEOUT_CYCLES : STEP_CYCLES;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int NDB  = 2;
  localparam logic [NDB-1:0] DB_RST = 2'b01;

  logic [NUM_IN-1:0] rawIn;
  logic [NUM_IN-1:0] syncIn;
  logic [NDB-1:0]    dbIn;
  logic [NDB-1:0]    dbOut;
  logic [CW-1:0]     tmr;

  assign rawIn = {mmcResetN, pwrInd, removeOk, approveIn, handleOpen, presentN};

  hps_sync #(.WIDTH(NUM_IN), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (rawIn),
    .dout(syncIn)
  );

  assign dbIn = {syncIn[IDX_HANDLE], syncIn[IDX_PRES]};

  generate
    for (genvar g = 0; g < NDB; g++) begin : g_deb
      hps_debounce #(.CYCLES(DEB_CYCLES), .RST_VAL(DB_RST[g])) u_deb (
        .clk   (clk),
        .rstN  (rstN),
        .din   (dbIn[g]),
        .stable(dbOut[g])
      );
    end
  endgenerate

  // shared dwell / timeout counter, cleared on each state change
  always_ff @(posedge clk) begin
    if (!rstN)                    tmr <= '0;
    else if (drv.clrTimer)        tmr <= '0;
    else if (tmr != CW'(TMAX))    tmr <= tmr + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) modEnableN <= 1'b0;
    else       modEnableN <= syncIn[IDX_MMC] & syncIn[IDX_PRES];
  end

  always_comb begin
    stat.present    = ~dbOut[0];
    stat.handle     = dbOut[1];
    stat.approved   = syncIn[IDX_APPR];
    stat.removeOk   = syncIn[IDX_RMOK];
    stat.pwrInd     = syncIn[IDX_PIND];
    stat.timeoutHit = (tmr >= CW'(TIMEOUT_CYCLES - 1));
    stat.stepDone   = (tmr >= CW'(STEP_CYCLES - 1));
  end

  assign mgmtPwrEn    = drv.mgmtOn;
  assign payloadPwrEn = drv.payloadOn;
  assign hpPrsntN     = ~drv.announce;
  assign hpAttnN      = ~drv.attention;
  assign blueLedReq   = drv.ledOn;
  assign errFlag      = drv.fault;
endmodule

// File: rtl/hps_control.sv
module hps_control
  import hps_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  hps_status_t stat,
  output hps_drive_t  drv
);
  hps_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:         if (stat.present) nextState = ST_MGMT_WAIT;
      ST_MGMT_WAIT:    if (stat.approved) nextState = ST_ANNOUNCE;
                       else if (stat.timeoutHit) nextState = ST_FAULT;
      ST_ANNOUNCE:     if (stat.pwrInd) nextState = ST_ACTIVE;
                       else if (stat.timeoutHit) nextState = ST_FAULT;
      ST_ACTIVE:       if (stat.handle && stat.removeOk) nextState = ST_RELEASE;
      ST_RELEASE:      if (!stat.pwrInd) nextState = ST_LED;
                       else if (stat.timeoutHit) nextState = ST_FAULT;
      ST_LED:          if (stat.stepDone) nextState = ST_DROP_PAYLOAD;
      ST_DROP_PAYLOAD: if (stat.stepDone) nextState = ST_PARKED;
      ST_PARKED:       nextState = ST_PARKED;
      ST_FAULT:        nextState = ST_FAULT;
      default:         nextState = ST_IDLE;
    endcase
    if (!stat.present) nextState = ST_IDLE;
  end

  always_comb begin
    drv = '0;
    unique case (state)
      ST_MGMT_WAIT: drv.mgmtOn = 1'b1;
      ST_ANNOUNCE, ST_RELEASE: begin
        drv.mgmtOn    = 1'b1;
        drv.payloadOn = 1'b1;
        drv.announce  = 1'b1;
        drv.attention = 1'b1;
      end
      ST_ACTIVE: begin
        drv.mgmtOn    = 1'b1;
        drv.payloadOn = 1'b1;
        drv.announce  = 1'b1;
      end
      ST_LED: begin
        drv.mgmtOn    = 1'b1;
        drv.payloadOn = 1'b1;
        drv.announce  = 1'b1;
        drv.ledOn     = 1'b1;
      end
      ST_DROP_PAYLOAD: begin
        drv.mgmtOn = 1'b1;
        drv.ledOn  = 1'b1;
      end
      ST_PARKED: drv.ledOn = 1'b1;
      ST_FAULT:  drv.fault = 1'b1;
      default:   drv = '0;
    endcase
    drv.clrTimer = (nextState != state);
  end
endmodule

// File: rtl/hps_slot_sequencer.sv
module hps_slot_sequencer
  import hps_pkg::*;
#(
  parameter int DEB_CYCLES     = 16,
  parameter int TIMEOUT_CYCLES = 100000,
  parameter int STEP_CYCLES    = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic presentN,
  input  logic mmcResetN,
  input  logic approveIn,
  input  logic handleOpen,
  input  logic removeOk,
  input  logic pwrInd,
  output logic mgmtPwrEn,
  output logic payloadPwrEn,
  output logic hpPrsntN,
  output logic hpAttnN,
  output logic blueLedReq,
  output logic errFlag,
  output logic modEnableN
);
  hps_drive_t  drv;
  hps_status_t stat;

  hps_control u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .stat(stat),
    .drv (drv)
  );

  hps_datapath #(
    .DEB_CYCLES    (DEB_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .STEP_CYCLES   (STEP_CYCLES)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .presentN    (presentN),
    .mmcResetN   (mmcResetN),
    .approveIn   (approveIn),
    .handleOpen  (handleOpen),
    .removeOk    (removeOk),
    .pwrInd      (pwrInd),
    .drv         (drv),
    .stat        (stat),
    .mgmtPwrEn   (mgmtPwrEn),
    .payloadPwrEn(payloadPwrEn),
    .hpPrsntN    (hpPrsntN),
    .hpAttnN     (hpAttnN),
    .blueLedReq  (blueLedReq),
    .errFlag     (errFlag),
    .modEnableN  (modEnableN)
  );
endmodule

// File: rtl/hps_checker.sv
module hps_checker (
  input logic clk,
  input logic rstN,
  input logic presentN,
  input logic mmcResetN,
  input logic mgmtPwrEn,
  input logic payloadPwrEn,
  input logic hpPrsntN,
  input logic hpAttnN,
  input logic blueLedReq,
  input logic errFlag,
  input logic modEnableN
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  p_payload_needs_mgmt_r8: assert property (@(posedge clk) disable iff (!rstN)
    payloadPwrEn |-> mgmtPwrEn);

  p_mgmt_before_payload_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(payloadPwrEn) |-> $past(mgmtPwrEn));

  p_attn_needs_payload_r4: assert property (@(posedge clk) disable iff (!rstN)
    !hpAttnN |-> (payloadPwrEn && !hpPrsntN));

  p_led_with_rails_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blueLedReq) |-> (payloadPwrEn && mgmtPwrEn));

  p_mgmt_after_payload_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(mgmtPwrEn) && blueLedReq) |-> $past(!payloadPwrEn));

  p_fault_all_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!mgmtPwrEn && !payloadPwrEn && hpPrsntN && hpAttnN));

  p_enable_and_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (modEnableN == $past(mmcResetN & presentN, 3)));
endmodule

bind hps_slot_sequencer hps_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .presentN    (presentN),
  .mmcResetN   (mmcResetN),
  .mgmtPwrEn   (mgmtPwrEn),
  .payloadPwrEn(payloadPwrEn),
  .hpPrsntN    (hpPrsntN),
  .hpAttnN     (hpAttnN),
  .blueLedReq  (blueLedReq),
  .errFlag     (errFlag),
  .modEnableN  (modEnableN)
);

// File: tb/hps_slot_sequencer_bench.sv
module hps_slot_sequencer_bench;
  localparam int DEB  = 4;
  localparam int TMO  = 64;
  localparam int STEP = 3;

  typedef enum int {PH_IDLE, PH_MGMT, PH_ANN, PH_ACT, PH_REL, PH_LED, PH_DROP, PH_PARK, PH_FAULT} phase_e;

  logic clk = 1'b0;
  logic rstN, presentN, mmcResetN, approveIn, handleOpen, removeOk, pwrInd;
  logic mgmtPwrEn, payloadPwrEn, hpPrsntN, hpAttnN, blueLedReq, errFlag, modEnableN;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  hps_slot_sequencer #(
    .DEB_CYCLES(DEB), .TIMEOUT_CYCLES(TMO), .STEP_CYCLES(STEP)
  ) u_hps_slot_sequencer (
    .clk(clk), .rstN(rstN), .presentN(presentN), .mmcResetN(mmcResetN),
    .approveIn(approveIn), .handleOpen(handleOpen), .removeOk(removeOk),
    .pwrInd(pwrInd), .mgmtPwrEn(mgmtPwrEn), .payloadPwrEn(payloadPwrEn),
    .hpPrsntN(hpPrsntN), .hpAttnN(hpAttnN), .blueLedReq(blueLedReq),
    .errFlag(errFlag), .modEnableN(modEnableN)
  );

  // {mgmt, payload, prsntN, attnN, led, err}
  function automatic logic [5:0] expOut(phase_e ph);
    case (ph)
      PH_MGMT:  return 6'b100100 | 6'b001000;
      PH_ANN:   return 6'b110000;
      PH_ACT:   return 6'b110100;
      PH_REL:   return 6'b110000;
      PH_LED:   return 6'b110110;
      PH_DROP:  return 6'b101110;
      PH_PARK:  return 6'b001110;
      PH_FAULT: return 6'b001101;
      default:  return 6'b001100;
    endcase
  endfunction

  function automatic logic [5:0] obs();
    return {mgmtPwrEn, payloadPwrEn, hpPrsntN, hpAttnN, blueLedReq, errFlag};
  endfunction

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pullModule(string req);
    presentN = 1'b1; approveIn = 1'b0; pwrInd = 1'b0;
    handleOpen = 1'b0; removeOk = 1'b0;
    cyc(DEB + 6);
    chk(req, obs(), expOut(PH_IDLE));
  endtask

  task automatic scenario();
    bit giveAppr = ($urandom % 4) != 0;
    bit confirm  = ($urandom % 4) != 0;
    bit permit   = ($urandom % 2) != 0;
    bit release_ = ($urandom % 4) != 0;
    int dly      = $urandom % (TMO / 2);
    presentN = 1'b0;
    cyc(DEB + 6);
    chk("R2 rand insert", obs(), expOut(PH_MGMT));
    if (!giveAppr) begin
      cyc(TMO + 8); chk("R9 rand no approval", obs(), expOut(PH_FAULT));
      pullModule("R10 rand pull"); return;
    end
    cyc(dly); approveIn = 1'b1; cyc(4);
    chk("R3 rand approve", obs(), expOut(PH_ANN));
    if (!confirm) begin
      cyc(TMO + 8); chk("R9 rand no confirm", obs(), expOut(PH_FAULT));
      pullModule("R10 rand pull"); return;
    end
    pwrInd = 1'b1; cyc(4);
    chk("R4 rand confirm", obs(), expOut(PH_ACT));
    handleOpen = 1'b1; removeOk = permit; cyc(DEB + 6);
    if (!permit) begin
      chk("R5 rand no permit", obs(), expOut(PH_ACT));
      pullModule("R10 rand pull"); return;
    end
    chk("R6 rand permit", obs(), expOut(PH_REL));
    if (!release_) begin
      cyc(TMO + 8); chk("R9 rand no release", obs(), expOut(PH_FAULT));
      pullModule("R10 rand pull"); return;
    end
    pwrInd = 1'b0; cyc(2 * STEP + 6);
    chk("R7 rand removal", obs(), expOut(PH_PARK));
    pullModule("R10 rand pull");
  endtask

  initial begin
    int wd = 0;
    while (!finished) begin
      @(negedge clk);
      wd++;
      if (wd > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", wd);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    rstN = 1'b0; presentN = 1'b1; mmcResetN = 1'b1; approveIn = 1'b0;
    handleOpen = 1'b0; removeOk = 1'b0; pwrInd = 1'b0;
    cyc(3);
    chk("R1 reset outputs", obs(), expOut(PH_IDLE));
    chk("R1 reset enable", {5'b0, modEnableN}, 6'b0);
    rstN = 1'b1;

    // R11 module enable pipeline
    cyc(4);
    chk("R11 enable high", {5'b0, modEnableN}, 6'b1);
    mmcResetN = 1'b0; cyc(2);
    chk("R11 enable before 3rd edge", {5'b0, modEnableN}, 6'b1);
    cyc(1);
    chk("R11 enable follows reset line", {5'b0, modEnableN}, 6'b0);
    mmcResetN = 1'b1; cyc(3);
    chk("R11 enable restored", {5'b0, modEnableN}, 6'b1);

    // R2 glitch rejection
    presentN = 1'b0; cyc(2); presentN = 1'b1; cyc(20);
    chk("R2 glitch ignored", obs(), expOut(PH_IDLE));

    // R2 exact insertion timing, R11 presence term
    presentN = 1'b0; cyc(3);
    chk("R11 presence drives enable", {5'b0, modEnableN}, 6'b0);
    cyc(3);
    chk("R2 before debounce", obs(), expOut(PH_IDLE));
    cyc(1);
    chk("R2 mgmt only", obs(), expOut(PH_MGMT));

    // R3 payload waits for approval
    cyc(20);
    chk("R3 no approval yet", obs(), expOut(PH_MGMT));
    approveIn = 1'b1; cyc(2);
    chk("R3 approval in sync", obs(), expOut(PH_MGMT));
    cyc(1);
    chk("R3 payload on", obs(), expOut(PH_ANN));

    // R4 announce until host confirms
    cyc(10);
    chk("R4 announce held", obs(), expOut(PH_ANN));
    pwrInd = 1'b1; cyc(3);
    chk("R4 confirmed", obs(), expOut(PH_ACT));

    // R5 handle without permission, R6 with permission
    handleOpen = 1'b1; cyc(20);
    chk("R5 no permission", obs(), expOut(PH_ACT));
    removeOk = 1'b1; cyc(4);
    chk("R6 attention pressed", obs(), expOut(PH_REL));
    cyc(20);
    chk("R6 rails held until release", obs(), expOut(PH_REL));

    // R7 exact removal order
    pwrInd = 1'b0; cyc(3);
    chk("R7 led first", obs(), expOut(PH_LED));
    cyc(STEP - 1);
    chk("R7 led dwell", obs(), expOut(PH_LED));
    cyc(1);
    chk("R7 payload off", obs(), expOut(PH_DROP));
    cyc(STEP - 1);
    chk("R7 payload-off dwell", obs(), expOut(PH_DROP));
    cyc(1);
    chk("R7 mgmt off", obs(), expOut(PH_PARK));
    pullModule("R10 after removal");

    // R10 presence lost mid-announce
    presentN = 1'b0; cyc(DEB + 6); approveIn = 1'b1; cyc(4);
    chk("R10 setup announce", obs(), expOut(PH_ANN));
    pullModule("R10 lost during announce");

    // R9 approval timeout
    presentN = 1'b0; cyc(DEB + 6); cyc(TMO - 8);
    chk("R9 still waiting", obs(), expOut(PH_MGMT));
    cyc(16);
    chk("R9 timeout fault", obs(), expOut(PH_FAULT));
    cyc(20);
    chk("R9 fault held", obs(), expOut(PH_FAULT));
    pullModule("R10 clears fault");

    for (int i = 0; i < 40; i++) scenario();

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule